// File: doc/BRIEF.md
# Decimal Accumulator Machine Sequencer

This block is a small accumulator processor core whose words hold decimal values from 0 to 999, kept in binary. Each instruction is a single word. Its hundreds digit selects the operation and its two low digits name a memory address. A control state machine walks each instruction through a fixed series of single register transfers. The program counter, memory address register, memory data register, instruction register, accumulator and an I/O register are the only places that state moves through. One transfer happens per clock.

The memory is internal: 100 words, single port, synchronous, with a one-cycle read latency. A preload port gives a host (or a testbench) access to the memory while the core is held in reset or has halted. The core takes input values through an input port with a request/valid pair and presents output values with a one-cycle valid strobe. It raises a halted flag when it stops. The program counter and accumulator are brought out so that the architectural state can be observed.

Top module: `dacc_core`

## Requirements
- R1: While reset is low, pc_out, acc_out, halted, out_valid and in_req all read 0. After reset the first fetch comes from address 0.
- R2: Every instruction begins with four fetch cycles, in this order: PC into MAR, a memory wait, the memory word into MDR, then MDR into IR. LOAD (hundreds digit 5) takes 9 cycles in total. It sets the accumulator to the addressed word, clears the negative flag and advances PC in its last cycle.
- R3: ADD (hundreds digit 1) takes 9 cycles. It sets the accumulator to (accumulator + word) mod 1000 and clears the negative flag. The accumulator never holds a value above 999.
- R4: SUBTRACT (hundreds digit 2) takes 9 cycles. It sets the accumulator to (accumulator - word) mod 1000. The negative flag is set exactly when the accumulator was smaller than the word.
- R5: STORE (hundreds digit 3) takes 8 cycles. It writes the accumulator through MDR into the addressed word and leaves the accumulator unchanged.
- R6: IN (the word 901) holds in_req high from its fifth cycle until in_valid is sampled high. It captures in_data in the I/O register, copies that value into the accumulator on the next cycle, clears the negative flag and advances PC.
- R7: OUT (the word 902) copies the accumulator into the I/O register, which drives out_data. out_valid is high for exactly one cycle, the sixth cycle of the instruction. The instruction takes 6 cycles.
- R8: An unconditional branch (hundreds digit 6) loads the address field into PC and takes 5 cycles.
- R9: Branch-if-zero (hundreds digit 7) loads the address field into PC when the accumulator is 0. Otherwise it advances PC. Either way it takes 5 cycles.
- R10: Branch-if-nonnegative (hundreds digit 8) loads the address field into PC when the negative flag is clear. Otherwise it advances PC. Either way it takes 5 cycles.
- R11: HALT (hundreds digit 0), hundreds digit 4 and any 9xx word other than 901 and 902 perform only the fetch. halted then rises in the fifth cycle and stays high until reset, with PC and the accumulator held.
- R12: Advancing PC from address 99 wraps it to 0.
- R13: Start with 665 at address 0, 590, 192, 390 and 000 at addresses 65 to 68, 111 at 90 and 222 at 92. The core must halt with 333 at address 90 and PC at 68.
- R14: When pre_en is high, the preload port owns the memory. A write with pre_we stores pre_wdata at pre_addr. A read returns the word on pre_rdata one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_data | input | WORD_W | Input value offered to an IN instruction |
| in_valid | input | 1 | in_data is valid this cycle |
| in_req | output | 1 | Core is waiting in an IN instruction |
| out_data | output | WORD_W | I/O register contents |
| out_valid | output | 1 | One-cycle strobe: out_data was just written by OUT |
| halted | output | 1 | Core has stopped sequencing |
| pc_out | output | ADDR_W | Program counter |
| acc_out | output | WORD_W | Accumulator |
| pre_en | input | 1 | Preload port owns the memory |
| pre_we | input | 1 | Preload write enable |
| pre_addr | input | ADDR_W | Preload address |
| pre_wdata | input | WORD_W | Preload write data |
| pre_rdata | output | WORD_W | Memory read data, one cycle after the address |

## Verification
The first program is the load/add/store sequence reached through an unconditional branch. It separates correct operand addressing and store data from off-by-one timing of the MAR/MDR transfers, and the final word at address 90 can only be 333 if all three operand paths are correct. The second program drives a subtract that underflows and then feeds the wrapped result through an add that overflows. This tells the negative flag apart from the accumulator value, because each conditional branch is exercised both taken and not taken. The same program uses an input that arrives only after several waiting cycles and an output at address 99, which forces PC to wrap. A third image halts on an unrecognised 9xx word. A behavioural model compares PC, the accumulator, the strobes and halted on every clock, so a transfer placed in the wrong cycle is visible even when the final state happens to be correct.

// File: rtl/dacc_pkg.sv
// Shared types for the decimal accumulator core.
// Assumes: three-digit decimal instruction words, hundreds digit = operation.
package dacc_pkg;

    localparam int RADIX       = 10;
    localparam int HUNDRED     = RADIX * RADIX;
    localparam int MODULUS     = HUNDRED * RADIX;
    localparam int CODE_IN     = 9 * HUNDRED + 1;
    localparam int CODE_OUT    = 9 * HUNDRED + 2;

    typedef enum logic [4:0] {
        S_F_MAR,
        S_F_WAIT,
        S_F_MDR,
        S_F_IR,
        S_OP_MAR,
        S_OP_WAIT,
        S_OP_MDR,
        S_OP_ALU,
        S_ST_MDR,
        S_ST_WR,
        S_IN_WAIT,
        S_IN_ACC,
        S_OUT_IO,
        S_BR,
        S_PC_INC,
        S_HALT
    } seq_state_t;

    typedef enum logic [3:0] {
        OP_HALT,
        OP_ADD,
        OP_SUB,
        OP_STORE,
        OP_LOAD,
        OP_BR,
        OP_BRZ,
        OP_BRP,
        OP_IN,
        OP_OUT
    } op_t;

    typedef enum logic [2:0] {
        ACC_KEEP,
        ACC_LOAD,
        ACC_ADD,
        ACC_SUB,
        ACC_IO
    } acc_sel_t;

    typedef struct packed {
        logic     mar_from_pc;
        logic     mar_from_ir;
        logic     mdr_from_mem;
        logic     mdr_from_acc;
        logic     ir_load;
        logic     io_from_in;
        logic     io_from_acc;
        logic     pc_inc;
        logic     pc_jump;
        logic     mem_we;
        acc_sel_t acc_sel;
    } ctl_t;

endpackage

// File: rtl/dacc_mem.sv
// Single-port synchronous word memory with one cycle of read latency.
// Assumes: addr stays below DEPTH; contents are not reset.
module dacc_mem #(
    parameter int DEPTH  = 100,
    parameter int WORD_W = 10,
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);

    logic [WORD_W-1:0] mem [DEPTH];

    // Write the addressed word and register the read data.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
        rdata <= mem[addr];
    end

    // R14: every write lands inside the array.
    a_r14_write_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (addr < ADDR_W'(DEPTH)));

endmodule

// File: rtl/dacc_ctrl.sv
// Instruction sequencer: one register transfer per state, fetch then execute.
// Assumes: mdr holds the fetched word in S_F_IR; ir is stable after S_F_IR.
module dacc_ctrl #(
    parameter int WORD_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] mdr,
    input  logic [WORD_W-1:0] ir,
    input  logic              acc_zero,
    input  logic              neg,
    input  logic              in_valid,
    output dacc_pkg::ctl_t    ctl,
    output logic              halted,
    output logic              in_req
);
    import dacc_pkg::*;

    seq_state_t state;
    seq_state_t nxt;
    op_t        op_fetch;
    op_t        op_cur;

    // Map a decimal instruction word onto an operation.
    function automatic op_t decode(input logic [WORD_W-1:0] w);
        int unsigned v;
        int unsigned hd;
        op_t         r;
        v  = {{(32-WORD_W){1'b0}}, w};
        hd = v / HUNDRED;
        case (hd)
            1:       r = OP_ADD;
            2:       r = OP_SUB;
            3:       r = OP_STORE;
            5:       r = OP_LOAD;
            6:       r = OP_BR;
            7:       r = OP_BRZ;
            8:       r = OP_BRP;
            9:       r = (v == CODE_IN)  ? OP_IN  :
                         (v == CODE_OUT) ? OP_OUT : OP_HALT;
            default: r = OP_HALT;
        endcase
        return r;
    endfunction

    assign op_fetch = decode(mdr);
    assign op_cur   = decode(ir);

    // Next-state and transfer selection for the current state.
    always_comb begin
        ctl = '0;
        nxt = state;
        case (state)
            S_F_MAR: begin
                ctl.mar_from_pc = 1'b1;
                nxt = S_F_WAIT;
            end
            S_F_WAIT: nxt = S_F_MDR;
            S_F_MDR: begin
                ctl.mdr_from_mem = 1'b1;
                nxt = S_F_IR;
            end
            S_F_IR: begin
                ctl.ir_load = 1'b1;
                case (op_fetch)
                    OP_LOAD, OP_ADD, OP_SUB, OP_STORE: nxt = S_OP_MAR;
                    OP_IN:   nxt = S_IN_WAIT;
                    OP_OUT:  nxt = S_OUT_IO;
                    OP_BR:   nxt = S_BR;
                    OP_BRZ:  nxt = acc_zero ? S_BR : S_PC_INC;
                    OP_BRP:  nxt = neg ? S_PC_INC : S_BR;
                    default: nxt = S_HALT;
                endcase
            end
            S_OP_MAR: begin
                ctl.mar_from_ir = 1'b1;
                nxt = (op_cur == OP_STORE) ? S_ST_MDR : S_OP_WAIT;
            end
            S_OP_WAIT: nxt = S_OP_MDR;
            S_OP_MDR: begin
                ctl.mdr_from_mem = 1'b1;
                nxt = S_OP_ALU;
            end
            S_OP_ALU: begin
                case (op_cur)
                    OP_LOAD: ctl.acc_sel = ACC_LOAD;
                    OP_ADD:  ctl.acc_sel = ACC_ADD;
                    OP_SUB:  ctl.acc_sel = ACC_SUB;
                    default: ctl.acc_sel = ACC_KEEP;
                endcase
                nxt = S_PC_INC;
            end
            S_ST_MDR: begin
                ctl.mdr_from_acc = 1'b1;
                nxt = S_ST_WR;
            end
            S_ST_WR: begin
                ctl.mem_we = 1'b1;
                nxt = S_PC_INC;
            end
            S_IN_WAIT: begin
                if (in_valid) begin
                    ctl.io_from_in = 1'b1;
                    nxt = S_IN_ACC;
                end
            end
            S_IN_ACC: begin
                ctl.acc_sel = ACC_IO;
                nxt = S_PC_INC;
            end
            S_OUT_IO: begin
                ctl.io_from_acc = 1'b1;
                nxt = S_PC_INC;
            end
            S_BR: begin
                ctl.pc_jump = 1'b1;
                nxt = S_F_MAR;
            end
            S_PC_INC: begin
                ctl.pc_inc = 1'b1;
                nxt = S_F_MAR;
            end
            S_HALT:  nxt = S_HALT;
            default: nxt = S_HALT;
        endcase
    end

    // State register with synchronous reset into the first fetch state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_F_MAR;
        end else begin
            state <= nxt;
        end
    end

    assign halted = (state == S_HALT);
    assign in_req = (state == S_IN_WAIT);

    // R2: PC-to-MAR is always followed by the memory wait.
    a_r2_fetch_order: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_F_MAR) |=> (state == S_F_WAIT));

    // R11: once stopped, the sequencer stays stopped.
    a_r11_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    // R6: without a valid input the core keeps requesting.
    a_r6_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (in_req && !in_valid) |=> in_req);

    // R8: a taken branch goes straight back to fetch.
    a_r8_branch_refetch: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_BR) |=> (state == S_F_MAR));

endmodule

// File: rtl/dacc_datapath.sv
// Register file of the core (PC, MAR, MDR, IR, ACC, I/O) and the mod-1000 ALU.
// Assumes: control enables are one-hot per destination; words stay below 1000.
module dacc_datapath #(
    parameter int DEPTH  = 100,
    parameter int WORD_W = 10,
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  dacc_pkg::ctl_t    ctl,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic [WORD_W-1:0] in_data,
    output logic [ADDR_W-1:0] mar,
    output logic [WORD_W-1:0] mdr,
    output logic [WORD_W-1:0] ir,
    output logic [ADDR_W-1:0] pc,
    output logic [WORD_W-1:0] acc,
    output logic [WORD_W-1:0] io,
    output logic              neg,
    output logic              out_valid
);
    import dacc_pkg::*;

    localparam logic [WORD_W:0]   MOD_W  = (WORD_W+1)'(MODULUS);
    localparam logic [WORD_W-1:0] HUND_W = WORD_W'(HUNDRED);
    localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(DEPTH - 1);

    logic [WORD_W-1:0] ir_low;
    logic [ADDR_W-1:0] addr_field;
    logic [ADDR_W-1:0] pc_seq;
    logic [WORD_W:0]   sum_raw;
    logic [WORD_W:0]   add_res;
    logic              borrow;
    logic [WORD_W:0]   sub_res;

    assign ir_low     = ir % HUND_W;
    assign addr_field = ir_low[ADDR_W-1:0];
    assign pc_seq     = (pc == LAST_A) ? '0 : pc + 1'b1;

    // Decimal wrap-around sum and difference of accumulator and MDR.
    always_comb begin
        sum_raw = {1'b0, acc} + {1'b0, mdr};
        add_res = (sum_raw >= MOD_W) ? (sum_raw - MOD_W) : sum_raw;
        borrow  = (acc < mdr);
        sub_res = borrow ? ({1'b0, acc} + MOD_W - {1'b0, mdr})
                         : ({1'b0, acc} - {1'b0, mdr});
    end

    // Program counter: jump to the address field or step with wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc <= '0;
        end else if (ctl.pc_jump) begin
            pc <= addr_field;
        end else if (ctl.pc_inc) begin
            pc <= pc_seq;
        end
    end

    // Memory address, data and instruction registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mar <= '0;
            mdr <= '0;
            ir  <= '0;
        end else begin
            if (ctl.mar_from_pc) mar <= pc;
            if (ctl.mar_from_ir) mar <= addr_field;
            if (ctl.mdr_from_mem) mdr <= mem_rdata;
            if (ctl.mdr_from_acc) mdr <= acc;
            if (ctl.ir_load) ir <= mdr;
        end
    end

    // Accumulator and negative flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
            neg <= 1'b0;
        end else begin
            case (ctl.acc_sel)
                ACC_LOAD: begin acc <= mdr;                  neg <= 1'b0;   end
                ACC_ADD:  begin acc <= add_res[WORD_W-1:0];  neg <= 1'b0;   end
                ACC_SUB:  begin acc <= sub_res[WORD_W-1:0];  neg <= borrow; end
                ACC_IO:   begin acc <= io;                   neg <= 1'b0;   end
                default:  ;
            endcase
        end
    end

    // I/O register and the output strobe that follows an OUT transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            io        <= '0;
            out_valid <= 1'b0;
        end else begin
            if (ctl.io_from_in)  io <= in_data;
            if (ctl.io_from_acc) io <= acc;
            out_valid <= ctl.io_from_acc;
        end
    end

    // R3: the accumulator stays a three-digit decimal value.
    a_r3_acc_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        acc < WORD_W'(MODULUS));

    // R12: PC never leaves the memory range.
    a_r12_pc_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        pc < ADDR_W'(DEPTH));

    // R7: the output strobe lasts one cycle.
    a_r7_out_single: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R4: the negative flag only rises after a subtract.
    a_r4_neg_from_sub: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(neg) |-> ($past(ctl.acc_sel) == ACC_SUB));

    // R5: the word written by STORE equals the accumulator.
    a_r5_store_data: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.mem_we |-> (mdr == acc));

endmodule

// File: rtl/dacc_core.sv
// Top of the decimal accumulator core: sequencer, datapath and word memory.
// Assumes: the preload port is used only in reset or after halt.
module dacc_core #(
    parameter int MEM_DEPTH = 100,
    parameter int WORD_W    = 10,
    parameter int ADDR_W    = $clog2(MEM_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_req,
    output logic [WORD_W-1:0] out_data,
    output logic              out_valid,
    output logic              halted,
    output logic [ADDR_W-1:0] pc_out,
    output logic [WORD_W-1:0] acc_out,
    input  logic              pre_en,
    input  logic              pre_we,
    input  logic [ADDR_W-1:0] pre_addr,
    input  logic [WORD_W-1:0] pre_wdata,
    output logic [WORD_W-1:0] pre_rdata
);
    import dacc_pkg::*;

    ctl_t              ctl;
    logic [ADDR_W-1:0] mar;
    logic [WORD_W-1:0] mdr;
    logic [WORD_W-1:0] ir;
    logic [ADDR_W-1:0] pc;
    logic [WORD_W-1:0] acc;
    logic [WORD_W-1:0] io;
    logic              neg;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_we;
    logic [WORD_W-1:0] mem_wdata;
    logic [WORD_W-1:0] mem_rdata;

    // Memory port ownership: preload port when enabled, else the core.
    always_comb begin
        if (pre_en) begin
            mem_addr  = pre_addr;
            mem_we    = pre_we;
            mem_wdata = pre_wdata;
        end else begin
            mem_addr  = mar;
            mem_we    = ctl.mem_we;
            mem_wdata = mdr;
        end
    end

    dacc_ctrl #(.WORD_W(WORD_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .mdr      (mdr),
        .ir       (ir),
        .acc_zero (acc == '0),
        .neg      (neg),
        .in_valid (in_valid),
        .ctl      (ctl),
        .halted   (halted),
        .in_req   (in_req)
    );

    dacc_datapath #(.DEPTH(MEM_DEPTH), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl       (ctl),
        .mem_rdata (mem_rdata),
        .in_data   (in_data),
        .mar       (mar),
        .mdr       (mdr),
        .ir        (ir),
        .pc        (pc),
        .acc       (acc),
        .io        (io),
        .neg       (neg),
        .out_valid (out_valid)
    );

    dacc_mem #(.DEPTH(MEM_DEPTH), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (mem_addr),
        .we    (mem_we),
        .wdata (mem_wdata),
        .rdata (mem_rdata)
    );

    assign out_data  = io;
    assign pc_out    = pc;
    assign acc_out   = acc;
    assign pre_rdata = mem_rdata;

    // R11: a halted core issues no memory write of its own.
    a_r11_no_write_when_halted: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !ctl.mem_we);

endmodule

// File: tb/dacc_core_tb.sv
`timescale 1ns/1ps
module dacc_core_tb;

    localparam int DEPTH = 100;
    localparam int WW    = 10;
    localparam int AW    = 7;

    localparam int K_FETCH = 0, K_LOAD = 1, K_ADD = 2, K_SUB = 3, K_STORE = 4,
                   K_IN = 5, K_OUT = 6, K_BR = 7, K_BRZ = 8, K_BRP = 9, K_HALT = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [WW-1:0] in_data = '0;
    logic          in_valid = 1'b0;
    logic          in_req;
    logic [WW-1:0] out_data;
    logic          out_valid;
    logic          halted;
    logic [AW-1:0] pc_out;
    logic [WW-1:0] acc_out;
    logic          pre_en = 1'b0;
    logic          pre_we = 1'b0;
    logic [AW-1:0] pre_addr = '0;
    logic [WW-1:0] pre_wdata = '0;
    logic [WW-1:0] pre_rdata;

    dacc_core u_dut (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
        .in_req(in_req), .out_data(out_data), .out_valid(out_valid),
        .halted(halted), .pc_out(pc_out), .acc_out(acc_out),
        .pre_en(pre_en), .pre_we(pre_we), .pre_addr(pre_addr),
        .pre_wdata(pre_wdata), .pre_rdata(pre_rdata)
    );

    always #4 clk = ~clk;

    int    n_chk = 0;
    int    n_err = 0;
    int    cyc = 0;
    bit    chk_on = 0;
    int    img [DEPTH];
    int    in_q[$];
    int    out_seen[$];
    int    wait_cnt = 0;

    // behavioural reference state
    int    m_mem [DEPTH];
    int    m_pc, m_acc, m_io, m_off, m_kind, m_addr;
    bit    m_neg;
    string m_tag = "R1";

    task automatic chk(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d (t=%0t)", tag, what, act, exp, $time);
        end
    endtask

    function automatic int inc_pc(int p);
        return (p == DEPTH - 1) ? 0 : p + 1;
    endfunction

    // Reference model: advance one cycle at each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_pc = 0; m_acc = 0; m_io = 0; m_neg = 0;
            m_off = 0; m_kind = K_FETCH; m_tag = "R1";
        end else if (m_off < 3) begin
            m_off++;
        end else if (m_off == 3) begin
            int w, hd;
            w = m_mem[m_pc]; hd = w / 100; m_addr = w % 100;
            case (hd)
                1: begin m_kind = K_ADD;   m_tag = "R3";  end
                2: begin m_kind = K_SUB;   m_tag = "R4";  end
                3: begin m_kind = K_STORE; m_tag = "R5";  end
                5: begin m_kind = K_LOAD;  m_tag = "R2";  end
                6: begin m_kind = K_BR;    m_tag = "R8";  end
                7: begin m_kind = K_BRZ;   m_tag = "R9";  end
                8: begin m_kind = K_BRP;   m_tag = "R10"; end
                9: begin
                    if (w == 901)      begin m_kind = K_IN;   m_tag = "R6";  end
                    else if (w == 902) begin m_kind = K_OUT;  m_tag = "R7";  end
                    else               begin m_kind = K_HALT; m_tag = "R11"; end
                end
                default: begin m_kind = K_HALT; m_tag = "R11"; end
            endcase
            m_off = 4;
        end else begin
            case (m_kind)
                K_LOAD, K_ADD, K_SUB: begin
                    if (m_off == 7) begin
                        if (m_kind == K_LOAD) begin m_acc = m_mem[m_addr]; m_neg = 0; end
                        else if (m_kind == K_ADD) begin
                            m_acc = (m_acc + m_mem[m_addr]) % 1000; m_neg = 0;
                        end else begin
                            m_neg = (m_acc < m_mem[m_addr]);
                            m_acc = (m_acc - m_mem[m_addr] + 1000) % 1000;
                        end
                        m_off++;
                    end else if (m_off == 8) begin
                        m_pc = inc_pc(m_pc); m_off = 0;
                    end else m_off++;
                end
                K_STORE: begin
                    if (m_off == 6) begin m_mem[m_addr] = m_acc; m_off++; end
                    else if (m_off == 7) begin m_pc = inc_pc(m_pc); m_off = 0; end
                    else m_off++;
                end
                K_IN: begin
                    if (m_off == 4) begin
                        if (in_valid) begin m_io = int'(in_data); m_off = 5; end
                    end else if (m_off == 5) begin
                        m_acc = m_io; m_neg = 0; m_off = 6;
                    end else begin
                        m_pc = inc_pc(m_pc); m_off = 0;
                    end
                end
                K_OUT: begin
                    if (m_off == 4) begin m_io = m_acc; m_off = 5; end
                    else begin m_pc = inc_pc(m_pc); m_off = 0; end
                end
                K_BR:  begin m_pc = m_addr; m_off = 0; end
                K_BRZ: begin m_pc = (m_acc == 0) ? m_addr : inc_pc(m_pc); m_off = 0; end
                K_BRP: begin m_pc = (!m_neg) ? m_addr : inc_pc(m_pc); m_off = 0; end
                default: ;
            endcase
        end
    end

    // Per-clock comparison away from the active edge.
    always @(negedge clk) begin
        if (chk_on) begin
            chk(m_tag, "pc", int'(pc_out), m_pc);
            chk(m_tag, "acc", int'(acc_out), m_acc);
            chk("R11", "halted", int'(halted), int'(m_kind == K_HALT && m_off >= 4));
            chk("R6", "in_req", int'(in_req), int'(m_kind == K_IN && m_off == 4));
            chk("R7", "out_valid", int'(out_valid), int'(m_kind == K_OUT && m_off == 5));
            if (out_valid) begin
                chk("R7", "out_data", int'(out_data), m_io);
                out_seen.push_back(int'(out_data));
            end
        end
    end

    // Input source: answer a request after three waiting cycles.
    always @(negedge clk) begin
        if (in_valid) begin
            in_valid = 1'b0;
        end else if (in_req) begin
            wait_cnt++;
            if (wait_cnt >= 3) begin
                in_data  = (in_q.size() > 0) ? WW'(in_q.pop_front()) : '0;
                in_valid = 1'b1;
                wait_cnt = 0;
            end
        end
    end

    // Global watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_err++; n_chk++;
            $display("FAIL R11 watchdog: actual=%0d expected=%0d", cyc, 150000);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    task automatic start_image();
        chk_on = 0;
        @(negedge clk);
        rst_n = 1'b0;
        for (int a = 0; a < DEPTH; a++) begin
            @(negedge clk);
            pre_en = 1'b1; pre_we = 1'b1;
            pre_addr = AW'(a); pre_wdata = WW'(img[a]);
            m_mem[a] = img[a];
        end
        @(negedge clk);
        pre_en = 1'b0; pre_we = 1'b0;
        @(negedge clk);
        chk("R1", "reset pc", int'(pc_out), 0);
        chk("R1", "reset acc", int'(acc_out), 0);
        chk("R1", "reset halted", int'(halted), 0);
        chk("R1", "reset out_valid", int'(out_valid), 0);
        chk("R1", "reset in_req", int'(in_req), 0);
        out_seen.delete();
        wait_cnt = 0;
        rst_n  = 1'b1;
        chk_on = 1;
    endtask

    task automatic run_to_halt(int limit);
        int n = 0;
        while (!halted && n < limit) begin
            @(negedge clk);
            n++;
        end
        chk("R11", "halt reached", int'(halted), 1);
        repeat (5) @(negedge clk);
        chk("R11", "halt sticky", int'(halted), 1);
    endtask

    task automatic read_word(int a, output int v);
        @(negedge clk);
        pre_en = 1'b1; pre_we = 1'b0; pre_addr = AW'(a);
        @(negedge clk);
        v = int'(pre_rdata);
        pre_en = 1'b0;
    endtask

    initial begin
        int v;
        // Image 1: load/add/store sequence entered by a branch.
        for (int a = 0; a < DEPTH; a++) img[a] = 0;
        img[0] = 665; img[65] = 590; img[66] = 192; img[67] = 390; img[68] = 0;
        img[90] = 111; img[92] = 222;
        start_image();
        run_to_halt(2000);
        chk("R13", "final pc", int'(pc_out), 68);
        chk("R3", "final acc", int'(acc_out), 333);
        read_word(90, v);
        chk("R13", "mem[90]", v, 333);
        read_word(92, v);
        chk("R14", "mem[92] via preload read", v, 222);

        // Image 2: underflow, overflow, conditional branches, I/O, PC wrap.
        for (int a = 0; a < DEPTH; a++) img[a] = 0;
        img[0] = 730; img[1] = 400;
        img[30] = 901; img[31] = 902; img[32] = 250; img[33] = 840;
        img[34] = 150; img[35] = 840;
        img[40] = 550; img[41] = 251; img[42] = 745;
        img[45] = 552; img[46] = 760; img[47] = 699;
        img[50] = 9; img[51] = 9; img[52] = 5;
        img[99] = 902;
        in_q.delete(); in_q.push_back(7);
        start_image();
        run_to_halt(4000);
        chk("R12", "pc after wrap and halt", int'(pc_out), 1);
        chk("R2", "final acc", int'(acc_out), 5);
        chk("R7", "output count", out_seen.size(), 2);
        if (out_seen.size() == 2) begin
            chk("R6", "first output echoes input", out_seen[0], 7);
            chk("R7", "second output", out_seen[1], 5);
        end

        // Image 3: unrecognised 9xx word halts at once.
        for (int a = 0; a < DEPTH; a++) img[a] = 0;
        img[0] = 955;
        start_image();
        run_to_halt(200);
        chk("R11", "pc held on unknown word", int'(pc_out), 0);

        chk_on = 0;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule